// File: doc/BRIEF.md
# Postponed Refresh Scheduler

This block manages refresh for a DRAM controller. Each refresh-interval tick adds one refresh to a backlog rather than being issued at once. When the read and write command buffers have both been empty for a programmed number of cycles, the backlog is sent out back to back. Before each further refresh in that burst, the buffers are checked again.

If traffic keeps the buffers busy until the backlog reaches its programmed limit, the block raises one refresh at urgent priority. After that single refresh it goes back to waiting for an idle window for the rest of the backlog. When deferral to self-refresh is enabled, idle-window refreshes wait until the controller reports that it is in self-refresh.

The command sequencer sees a level request. It returns a one-cycle acknowledge for each refresh it completes. DRAM timing is handled by the sequencer.

Top module: `rfs_sched`

## Requirements
- R1: The backlog rises by one on each interval tick and falls by one on each acknowledge given while a request is raised. A tick and an acknowledge in the same cycle leave it unchanged. It saturates at 8. An acknowledge while no request is raised has no effect.
- R2: During and after reset, with no ticks, both `ref_req_o` and `ref_urgent_o` are 0.
- R3: A non-urgent request rises on the clock edge at which the backlog is non-zero, both buffers are empty, and both have already been empty for at least `cfg_idle_i` consecutive earlier cycles (0 to 15). Any cycle with either buffer non-empty restarts that count from zero.
- R4: `ref_req_o` stays high until acknowledged. During a burst, refreshes follow one per acknowledge while both buffers stay empty, until the backlog reaches zero. The request then drops.
- R5: If either buffer is non-empty in the cycle of a burst acknowledge, the request drops and the remaining backlog waits for a new idle window.
- R6: When the backlog reaches the effective limit while no request is raised, `ref_req_o` and `ref_urgent_o` (1 = urgent) rise together one edge later, whatever the buffer state.
- R7: An urgent request covers exactly one refresh. On its acknowledge, `ref_urgent_o` falls, and the rest of the backlog waits for an idle window.
- R8: The effective limit is `cfg_limit_i`, except that 0 is treated as 1 and values above 8 are treated as 8.
- R9: While `sr_defer_en_i` is 1, no non-urgent request starts unless `sr_active_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ivl_tick_i | input | 1 | One-cycle refresh-interval tick |
| rdq_empty_i | input | 1 | Read command buffer empty |
| wrq_empty_i | input | 1 | Write command buffer empty |
| cfg_limit_i | input | 4 | Backlog limit (0 acts as 1, above 8 acts as 8) |
| cfg_idle_i | input | 4 | Idle cycles required before a burst |
| sr_defer_en_i | input | 1 | Hold idle refreshes until self-refresh is entered |
| sr_active_i | input | 1 | Controller is in self-refresh |
| ref_ack_i | input | 1 | One refresh completed |
| ref_req_o | output | 1 | Refresh command request |
| ref_urgent_o | output | 1 | Current request is urgent |

## Verification
The idle gate is tested with a window interrupted by one busy cycle, and the edge at which the request rises is checked exactly. This separates a count that restarts from one that only pauses. Backlogs of different sizes are drained with acknowledges every cycle. A second burst is cut short by a busy read buffer, which shows the difference between re-checking the buffers per refresh and issuing a whole batch at once. The urgent path is tried with limits of 0, 4, 12 and 8 with excess ticks, so that clamping, saturation and the single-refresh rule each change the number of refreshes that follow. A stray acknowledge with nothing pending, and a wait with self-refresh deferral enabled, show whether either can change the refresh count.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_BURST  = 2'd1,
    ST_URGENT = 2'd2
  } rfs_state_e;
endpackage

// File: rtl/rfs_pend_ctr.sv
module rfs_pend_ctr #(
  parameter int MAX_PEND = 8,
  parameter int CNT_W    = $clog2(MAX_PEND + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_PEND);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_ok;
  logic             cnt_en;

  assign dec_ok = dec_i && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc_i, dec_ok})
      2'b10:   if (cnt_q != MAX_V) cnt_d = cnt_q + ONE_V;
      2'b01:   cnt_d = cnt_q - ONE_V;
      default: cnt_d = cnt_q;
    endcase
  end

  assign cnt_en = inc_i || dec_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
endmodule

// File: rtl/rfs_idle_mon.sv
module rfs_idle_mon #(
  parameter int IDLE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bufs_empty_i,
  input  logic [IDLE_W-1:0] cfg_idle_i,
  output logic [IDLE_W-1:0] idle_cnt_o,
  output logic              window_ok_o
);
  localparam logic [IDLE_W-1:0] IDLE_MAX = {IDLE_W{1'b1}};

  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              idle_en;

  always_comb begin
    if (!bufs_empty_i)          idle_d = '0;
    else if (idle_q != IDLE_MAX) idle_d = idle_q + IDLE_W'(1);
    else                         idle_d = idle_q;
  end

  assign idle_en = (idle_d != idle_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (idle_en) begin
      idle_q <= idle_d;
    end
  end

  assign idle_cnt_o  = idle_q;
  assign window_ok_o = bufs_empty_i && (idle_q >= cfg_idle_i);
endmodule

// File: rtl/rfs_fsm.sv
module rfs_fsm
  import rfs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] pend_i,
  input  logic [CNT_W-1:0] pend_nxt_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             window_ok_i,
  input  logic             bufs_empty_i,
  input  logic             sr_gate_i,
  input  logic             ack_i,
  output rfs_state_e       state_o
);
  rfs_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT: begin
        if (pend_i >= limit_i)
          state_d = ST_URGENT;
        else if ((pend_i != '0) && window_ok_i && sr_gate_i)
          state_d = ST_BURST;
      end
      ST_BURST: begin
        if (ack_i) begin
          if ((pend_nxt_i != '0) && bufs_empty_i && sr_gate_i) state_d = ST_BURST;
          else                                                   state_d = ST_WAIT;
        end
      end
      ST_URGENT: begin
        if (ack_i) state_d = ST_WAIT;
      end
      default: state_d = ST_WAIT;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/rfs_sched.sv
module rfs_sched
  import rfs_pkg::*;
#(
  parameter int MAX_PEND = 8,
  parameter int IDLE_W   = 4,
  parameter int CNT_W    = $clog2(MAX_PEND + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ivl_tick_i,
  input  logic              rdq_empty_i,
  input  logic              wrq_empty_i,
  input  logic [CNT_W-1:0]  cfg_limit_i,
  input  logic [IDLE_W-1:0] cfg_idle_i,
  input  logic              sr_defer_en_i,
  input  logic              sr_active_i,
  input  logic              ref_ack_i,
  output logic              ref_req_o,
  output logic              ref_urgent_o
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_PEND);

  logic              rst_s1_q, rst_sync_n;
  logic              bufs_empty;
  logic              sr_gate;
  logic              ack_taken;
  logic [CNT_W-1:0]  lim_eff;
  logic [CNT_W-1:0]  pend_cnt, pend_nxt;
  logic [IDLE_W-1:0] idle_cnt;
  logic              window_ok;
  rfs_state_e        state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  assign bufs_empty = rdq_empty_i && wrq_empty_i;
  assign sr_gate    = !sr_defer_en_i || sr_active_i;
  assign ack_taken  = ref_ack_i && (state != ST_WAIT);

  always_comb begin
    if (cfg_limit_i == '0)        lim_eff = CNT_W'(1);
    else if (cfg_limit_i > MAX_V) lim_eff = MAX_V;
    else                          lim_eff = cfg_limit_i;
  end

  rfs_pend_ctr #(.MAX_PEND(MAX_PEND), .CNT_W(CNT_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .inc_i     (ivl_tick_i),
    .dec_i     (ack_taken),
    .cnt_o     (pend_cnt),
    .cnt_nxt_o (pend_nxt)
  );

  rfs_idle_mon #(.IDLE_W(IDLE_W)) u_idle (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .bufs_empty_i (bufs_empty),
    .cfg_idle_i   (cfg_idle_i),
    .idle_cnt_o   (idle_cnt),
    .window_ok_o  (window_ok)
  );

  rfs_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .pend_i       (pend_cnt),
    .pend_nxt_i   (pend_nxt),
    .limit_i      (lim_eff),
    .window_ok_i  (window_ok),
    .bufs_empty_i (bufs_empty),
    .sr_gate_i    (sr_gate),
    .ack_i        (ref_ack_i),
    .state_o      (state)
  );

  assign ref_req_o    = (state != ST_WAIT);
  assign ref_urgent_o = (state == ST_URGENT);
endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk #(
  parameter int MAX_PEND = 8,
  parameter int IDLE_W   = 4,
  parameter int CNT_W    = 4
) (
  input logic              clk_i,
  input logic              rst_sync_n,
  input logic              ivl_tick_i,
  input logic              rdq_empty_i,
  input logic              wrq_empty_i,
  input logic [IDLE_W-1:0] cfg_idle_i,
  input logic              sr_defer_en_i,
  input logic              sr_active_i,
  input logic              ref_ack_i,
  input logic              ref_req_o,
  input logic              ref_urgent_o,
  input logic [CNT_W-1:0]  pend_cnt,
  input logic [CNT_W-1:0]  lim_eff,
  input logic [IDLE_W-1:0] idle_cnt
);
  p_pend_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    pend_cnt <= CNT_W'(MAX_PEND));

  p_stray_ack_r1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!ref_req_o && ref_ack_i && !ivl_tick_i) |=> (pend_cnt == $past(pend_cnt)));

  p_idle_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(rdq_empty_i && wrq_empty_i) |=> (idle_cnt == '0));

  p_burst_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ($rose(ref_req_o) && !ref_urgent_o) |->
      ($past(rdq_empty_i && wrq_empty_i) && ($past(idle_cnt) >= $past(cfg_idle_i))));

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (ref_req_o && !ref_ack_i) |=> ref_req_o);

  p_burst_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (ref_req_o && !ref_urgent_o && ref_ack_i && !(rdq_empty_i && wrq_empty_i)) |=> !ref_req_o);

  p_urgent_req_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ref_urgent_o |-> ref_req_o);

  p_urgent_single_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (ref_urgent_o && ref_ack_i) |=> !ref_urgent_o);

  p_urgent_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(ref_urgent_o) |-> ($past(pend_cnt) >= $past(lim_eff)));

  p_sr_defer_r9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ($rose(ref_req_o) && !ref_urgent_o) |-> (!$past(sr_defer_en_i) || $past(sr_active_i)));
endmodule

bind rfs_sched rfs_sched_chk #(
  .MAX_PEND (MAX_PEND),
  .IDLE_W   (IDLE_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_sync_n    (rst_sync_n),
  .ivl_tick_i    (ivl_tick_i),
  .rdq_empty_i   (rdq_empty_i),
  .wrq_empty_i   (wrq_empty_i),
  .cfg_idle_i    (cfg_idle_i),
  .sr_defer_en_i (sr_defer_en_i),
  .sr_active_i   (sr_active_i),
  .ref_ack_i     (ref_ack_i),
  .ref_req_o     (ref_req_o),
  .ref_urgent_o  (ref_urgent_o),
  .pend_cnt      (pend_cnt),
  .lim_eff       (lim_eff),
  .idle_cnt      (idle_cnt)
);

// File: tb/rfs_sched_bench.sv
`timescale 1ns/1ps
module rfs_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, rd_e, wr_e, sr_en, sr_in;
  logic [3:0] lim, idle;
  logic       man_ack, ack_auto, auto_ack;
  logic       ack;
  logic       req, urg;

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_q[$];

  always #2.5 clk = ~clk;

  assign ack = man_ack | ack_auto;

  rfs_sched u_rfs_sched (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ivl_tick_i    (tick),
    .rdq_empty_i   (rd_e),
    .wrq_empty_i   (wr_e),
    .cfg_limit_i   (lim),
    .cfg_idle_i    (idle),
    .sr_defer_en_i (sr_en),
    .sr_active_i   (sr_in),
    .ref_ack_i     (ack),
    .ref_req_o     (req),
    .ref_urgent_o  (urg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: acknowledges each raised request and compares its urgency
  always @(negedge clk) begin
    if (auto_ack && req) begin
      if (exp_q.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R4 unexpected refresh: actual urgent=%0d expected none", urg);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk("R6 urgency of issued refresh", int'(urg), int'(e));
      end
      ack_auto <= 1'b1;
    end else begin
      ack_auto <= 1'b0;
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic ack_pulse();
    @(negedge clk) man_ack = 1'b1;
    @(negedge clk) man_ack = 1'b0;
  endtask

  task automatic busy();
    @(negedge clk) begin rd_e = 1'b0; wr_e = 1'b0; end
  endtask

  task automatic drain(input int n, input bit u, input string tag);
    for (int i = 0; i < n; i++) exp_q.push_back(u);
    @(negedge clk) begin rd_e = 1'b1; wr_e = 1'b1; end
    repeat (40) @(negedge clk);
    chk({tag, " backlog fully drained"}, exp_q.size(), 0);
    chk({tag, " request low after drain"}, int'(req), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; rd_e = 1'b0; wr_e = 1'b0;
    sr_en = 1'b0; sr_in = 1'b0; lim = 4'd8; idle = 4'd2;
    man_ack = 1'b0; ack_auto = 1'b0; auto_ack = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 req in reset", int'(req), 0);
    chk("R2 urgent in reset", int'(urg), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 req after reset", int'(req), 0);

    // R1 / R4: backlog of three held while busy, then drained
    ticks(3);
    repeat (5) @(negedge clk);
    chk("R3 no request while buffers busy", int'(req), 0);
    drain(3, 1'b0, "R4");

    // R3: idle window restarts after a busy cycle, exact rise edge
    busy();
    auto_ack = 1'b0; idle = 4'd3;
    ticks(1);
    @(negedge clk) begin rd_e = 1'b1; wr_e = 1'b1; end
    repeat (2) @(negedge clk);
    rd_e = 1'b0;
    @(negedge clk) rd_e = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 request held back before window", int'(req), 0);
    @(negedge clk);
    chk("R3 request rises at window edge", int'(req), 1);
    ack_pulse();
    chk("R4 request drops at zero backlog", int'(req), 0);

    // R4 hold and R5 abort
    busy();
    idle = 4'd0;
    ticks(4);
    @(negedge clk) begin rd_e = 1'b1; wr_e = 1'b1; end
    @(negedge clk);
    chk("R3 zero threshold starts at once", int'(req), 1);
    repeat (3) @(negedge clk);
    chk("R4 request held without ack", int'(req), 1);
    man_ack = 1'b1; rd_e = 1'b0;
    @(negedge clk) man_ack = 1'b0;
    chk("R5 burst stops on busy buffer", int'(req), 0);
    repeat (5) @(negedge clk);
    chk("R5 remainder waits while busy", int'(req), 0);
    auto_ack = 1'b1;
    drain(3, 1'b0, "R5");

    // R6 / R7: limit 4, urgent escalation exactly once
    busy();
    auto_ack = 1'b0; lim = 4'd4;
    ticks(4);
    chk("R6 no urgent before limit seen", int'(urg), 0);
    @(negedge clk);
    chk("R6 request at limit", int'(req), 1);
    chk("R6 urgent flag at limit", int'(urg), 1);
    ack_pulse();
    chk("R7 urgent clears after one", int'(urg), 0);
    repeat (5) @(negedge clk);
    chk("R7 rest waits while busy", int'(req), 0);
    auto_ack = 1'b1;
    drain(3, 1'b0, "R7");

    // R8: limit 0 acts as 1
    busy();
    lim = 4'd0;
    exp_q.push_back(1'b1);
    ticks(1);
    repeat (6) @(negedge clk);
    chk("R8 limit zero gives one urgent", exp_q.size(), 0);

    // R8: limit 12 acts as 8
    lim = 4'd12;
    exp_q.push_back(1'b1);
    ticks(8);
    repeat (6) @(negedge clk);
    chk("R8 limit above max clamps", exp_q.size(), 0);
    drain(7, 1'b0, "R8");

    // R1: saturation at eight
    busy();
    auto_ack = 1'b0; lim = 4'd8;
    ticks(10);
    chk("R1 urgent held unacked", int'(urg), 1);
    ack_pulse();
    chk("R1 single urgent after saturation", int'(urg), 0);
    auto_ack = 1'b1;
    drain(7, 1'b0, "R1");

    // R1: acknowledge without request ignored
    busy();
    auto_ack = 1'b0;
    ack_pulse();
    ack_pulse();
    auto_ack = 1'b1;
    ticks(1);
    drain(1, 1'b0, "R1");

    // R9: self-refresh deferral
    busy();
    sr_en = 1'b1; sr_in = 1'b0;
    ticks(2);
    @(negedge clk) begin rd_e = 1'b1; wr_e = 1'b1; end
    repeat (10) @(negedge clk);
    chk("R9 idle refresh deferred", int'(req), 0);
    exp_q.push_back(1'b0);
    exp_q.push_back(1'b0);
    sr_in = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 issued after self-refresh entry", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule